// File: doc/BRIEF.md
# Dual Programmable Timer/Counter

This peripheral holds a parameterised number of identical 32-bit timer/counters (two by default) behind a simple 32-bit register bus. Each channel has a control/status word, a load value and a read-only count. A channel counts up or down from a value copied out of its load register. When it rolls over it either reloads and keeps running, or stops. Each rollover sets a sticky event flag that software clears by writing a one to it, so writing back the status value it has just read acknowledges the event. A per-channel enable gates each flag onto one shared, registered interrupt line.

The bus takes a word address. Channel `i` occupies word addresses `4*i` to `4*i+3` (byte offsets 0x00/0x04/0x08 for channel 0 and 0x10/0x14/0x18 for channel 1). Reads are combinational from the addressed register. A write takes effect at the rising clock edge on which `bus_sel` and `bus_wr` are both high. A typical use runs channel 0 as a periodic or single-shot down-counting event source and channel 1 as a free-running up counter.

Top module: `duo_tmr`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Word address `4*i+0` selects channel `i`'s control word, `4*i+1` its load register (readable and writable) and `4*i+2` its count. Word `4*i+3` reads zero.
- R3: While control bit 5 (load) is held, the count is forced to the load register value, and it does not count. Counting starts on the first edge after the edge at which the stored load bit becomes clear.
- R4: With control bit 7 (enable) set, the count moves by one on every edge: down when bit 1 is set, up when bit 1 is clear.
- R5: A rollover happens when a down count steps from 0, or an up count steps from all-ones. With bit 4 (reload) set, the count takes the load value and keeps running. With bit 4 clear, it wraps (to all-ones when counting down, to 0 when counting up) and bit 7 clears, so counting stops.
- R6: Bit 8 (event flag) sets on rollover. Writing 1 to bit 8 clears it, and writing 0 to bit 8 leaves it unchanged.
- R7: If a rollover and a write that clears the flag land on the same edge, the flag ends up set.
- R8: `irq` is high one edge after any channel has both bit 6 (interrupt enable) and bit 8 set. A set flag with bit 6 clear never raises `irq`.
- R9: A write that clears bit 7 stops the count. The value after that write edge is held unchanged.
- R10: Writes to the count address are ignored. Control bits 31:11 always read zero.
- R11: Control bits 0, 2, 3, 9 and 10 are stored and read back, and have no effect on counting.
- R12: A single write that sets both bit 5 and bit 7 loads the count at that edge. The count holds until a later write clears bit 5, and it increments on the edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Word address (channel index in the upper bits, register in [1:0]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Shared registered interrupt |

## Verification
A software write to a control word and a rollover can land on the same edge. Both update the event flag, and a write that asks to clear the flag must not erase an event that is occurring at that moment. The bench lets a down counter with period four run until its count reaches zero. It then issues the acknowledge write so that it lands on exactly the rollover edge, and requires that the flag still reads set and the count reads the load value. A second acknowledge, one edge later, must clear the flag. A write that sets the load bit on an edge where an up counter would wrap is also covered: the load must win and no event may be recorded.

// File: rtl/duo_tmr_pkg.sv
package duo_tmr_pkg;

   localparam int CTL_W   = 11;
   localparam int B_LOAD  = 5;
   localparam int B_FLAG  = 8;

   // Field order fixes the bit positions seen on the bus.
   typedef struct packed {
      logic cascade;   // 10
      logic pwm_en;    // 9
      logic irq_flag;  // 8
      logic run_en;    // 7
      logic irq_en;    // 6
      logic ld;        // 5
      logic reload;    // 4
      logic capt_en;   // 3
      logic gen_en;    // 2
      logic dn;        // 1
      logic mode;      // 0
   } ctl_t;

   typedef enum logic [1:0] {
      REG_CTL = 2'd0,
      REG_LD  = 2'd1,
      REG_CNT = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/duo_tmr_step.sv
module duo_tmr_step #(
   parameter int CNT_W = 32
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] ld_val_i,
   input  logic             dn_i,
   input  logic             reload_i,
   output logic [CNT_W-1:0] nxt_o,
   output logic             wrap_o
);

   logic             at_floor;
   logic             at_ceil;
   logic [CNT_W-1:0] stepped;

   assign at_floor = (cnt_i == '0);
   assign at_ceil  = &cnt_i;
   assign stepped  = dn_i ? (cnt_i - 1'b1) : (cnt_i + 1'b1);
   assign wrap_o   = dn_i ? at_floor : at_ceil;

   // Without reload the natural step already lands on the wrap value.
   always_comb begin
      if (wrap_o && reload_i) nxt_o = ld_val_i;
      else                    nxt_o = stepped;
   end

endmodule

// File: rtl/duo_tmr_chan.sv
module duo_tmr_chan
   import duo_tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl_i,
   input  logic              wr_ld_i,
   input  logic [DATA_W-1:0] wdata_i,
   output ctl_t              ctl_o,
   output logic [CNT_W-1:0]  ld_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              irq_req_o
);

   ctl_t             ctl_q, ctl_d, ctl_wv;
   logic [CNT_W-1:0] ld_q;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] step_nxt;
   logic             step_wrap;
   logic             force_ld;
   logic             run;
   logic             fire;

   assign ctl_wv   = ctl_t'(wdata_i[CTL_W-1:0]);
   assign force_ld = ctl_q.ld | (wr_ctl_i & wdata_i[B_LOAD]);
   assign run      = ctl_q.run_en & ~ctl_q.ld;
   assign fire     = run & ~force_ld & step_wrap;

   duo_tmr_step #(.CNT_W(CNT_W)) u_step (
      .cnt_i   (cnt_q),
      .ld_val_i(ld_q),
      .dn_i    (ctl_q.dn),
      .reload_i(ctl_q.reload),
      .nxt_o   (step_nxt),
      .wrap_o  (step_wrap)
   );

   always_comb begin
      ctl_d = ctl_q;
      if (wr_ctl_i) begin
         ctl_d          = ctl_wv;
         ctl_d.irq_flag = ctl_q.irq_flag & ~ctl_wv.irq_flag;
      end
      if (fire) begin
         ctl_d.irq_flag = 1'b1;
         if (!ctl_q.reload) ctl_d.run_en = 1'b0;
      end
   end

   always_comb begin
      if (force_ld) cnt_d = ld_q;
      else if (run) cnt_d = step_nxt;
      else          cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         ld_q  <= '0;
         cnt_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         cnt_q <= cnt_d;
         if (wr_ld_i) ld_q <= wdata_i[CNT_W-1:0];
      end
   end

   assign ctl_o     = ctl_q;
   assign ld_o      = ld_q;
   assign cnt_o     = cnt_q;
   assign irq_req_o = ctl_q.irq_flag & ctl_q.irq_en;

   // R3
   ld_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.ld |=> (cnt_q == $past(ld_q)));

   // R9
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.run_en && !force_ld) |=> $stable(cnt_q));

   // R6
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_q.irq_flag) |-> $past(wr_ctl_i && wdata_i[B_FLAG]));

   // R7
   flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> ctl_q.irq_flag);

   // R5
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !ctl_q.reload) |=> !ctl_q.run_en);

endmodule

// File: rtl/duo_tmr_irq.sv
module duo_tmr_irq #(
   parameter int N_SRC   = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_i,
   output logic             irq_o
);

   logic any_req;
   assign any_req = |req_i;

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_req;
         end
         assign irq_o = irq_q;

         // R8
         irq_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            any_req |=> irq_o);
      end else begin : g_comb
         assign irq_o = any_req;
      end
   endgenerate

endmodule

// File: rtl/duo_tmr.sv
module duo_tmr
   import duo_tmr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 32,
   parameter int NUM_TMR = 2,
   parameter bit IRQ_REG = 1'b1,
   localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
   localparam int AW     = SEL_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   generate
      if (DATA_W < CTL_W)                  begin : g_bad_dw  $error("DATA_W too small"); end
      if (CNT_W < 2 || CNT_W > DATA_W)     begin : g_bad_cw  $error("CNT_W out of range"); end
      if (NUM_TMR < 1 || NUM_TMR > 4)      begin : g_bad_n   $error("NUM_TMR out of range"); end
   endgenerate

   logic [SEL_W-1:0] ch_idx;
   reg_sel_e         reg_idx;
   logic             wr_en;

   assign ch_idx  = bus_addr[AW-1:2];
   assign reg_idx = reg_sel_e'(bus_addr[1:0]);
   assign wr_en   = bus_sel & bus_wr;

   ctl_t             ch_ctl [NUM_TMR];
   logic [CNT_W-1:0] ch_ld  [NUM_TMR];
   logic [CNT_W-1:0] ch_cnt [NUM_TMR];
   logic [NUM_TMR-1:0] ch_req;

   generate
      for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
         logic hit;
         assign hit = wr_en && (ch_idx == SEL_W'(g));
         duo_tmr_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctl_i (hit && reg_idx == REG_CTL),
            .wr_ld_i  (hit && reg_idx == REG_LD),
            .wdata_i  (bus_wdata),
            .ctl_o    (ch_ctl[g]),
            .ld_o     (ch_ld[g]),
            .cnt_o    (ch_cnt[g]),
            .irq_req_o(ch_req[g])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_TMR; i++) begin
         if (ch_idx == SEL_W'(i)) begin
            case (reg_idx)
               REG_CTL: bus_rdata[CTL_W-1:0] = ch_ctl[i];
               REG_LD:  bus_rdata[CNT_W-1:0] = ch_ld[i];
               REG_CNT: bus_rdata[CNT_W-1:0] = ch_cnt[i];
               default: bus_rdata = '0;
            endcase
         end
      end
   end

   duo_tmr_irq #(.N_SRC(NUM_TMR), .IRQ_REG(IRQ_REG)) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .req_i(ch_req),
      .irq_o(irq)
   );

   // R10
   ctl_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx == REG_CTL) |-> (bus_rdata[DATA_W-1:CTL_W] == '0));

endmodule

// File: tb/duo_tmr_tb.sv
`timescale 1ns/1ps
module duo_tmr_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   always #10 clk = ~clk;

   duo_tmr u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // word addresses
   localparam logic [2:0] C0 = 3'd0, L0 = 3'd1, N0 = 3'd2, X0 = 3'd3;
   localparam logic [2:0] C1 = 3'd4, L1 = 3'd5, N1 = 3'd6;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  samp_ev;
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 0;

   // monitor: pops one expected item per sample and compares
   initial forever begin
      item_t it;
      logic [31:0] act;
      @(samp_ev);
      it  = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      n_vec++;
      if (act !== it.exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #2;
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.is_irq = 0; it.exp = e; it.tag = tag;
      bus_addr = a;
      q.push_back(it);
      #1 -> samp_ev;
      #1;
   endtask

   task automatic ck_irq(input logic e, input string tag);
      item_t it;
      it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
      q.push_back(it);
      #1 -> samp_ev;
      #1;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         n_vec++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(C0, 32'h0, "R1 ctl0"); rd(L0, 32'h0, "R1 ld0");
      rd(N0, 32'h0, "R1 cnt0"); rd(C1, 32'h0, "R1 ctl1");
      ck_irq(1'b0, "R1 irq");

      // down counter, reload, interrupt enabled, channel 0
      wr(L0, 32'd3);
      rd(L0, 32'd3, "R2 ld0 readback");
      rd(X0, 32'h0, "R2 unused word");
      wr(C0, 32'h20);
      rd(N0, 32'd3, "R3 load forces count");
      wr(C0, 32'hD2);                     // E1
      rd(N0, 32'd3, "R3 still loaded at clearing edge");
      rd(C0, 32'hD2, "R2 ctl0 readback");
      idle(1);
      rd(N0, 32'd2, "R4 down step");
      idle(2);
      rd(N0, 32'd0, "R4 reach zero");
      ck_irq(1'b0, "R8 no irq before event");
      idle(1);                            // E5 rollover
      rd(N0, 32'd3, "R5 reload on rollover");
      rd(C0, 32'h1D2, "R6 flag set");
      ck_irq(1'b0, "R8 irq one edge later");
      idle(1);
      ck_irq(1'b1, "R8 irq raised");
      idle(2);                            // E8 count 0
      rd(N0, 32'd0, "R4 zero again");
      wr(C0, 32'h1D2);                    // ack on rollover edge
      rd(C0, 32'h1D2, "R7 flag kept on collision");
      rd(N0, 32'd3, "R7 reload on collision edge");
      wr(C0, 32'h1D2);                    // plain ack
      rd(C0, 32'hD2, "R6 flag cleared by write-back");
      rd(N0, 32'd2, "R4 count continues");
      ck_irq(1'b1, "R8 irq lags clear");
      idle(1);
      ck_irq(1'b0, "R8 irq dropped");
      rd(N0, 32'd1, "R4 count 1");
      wr(C0, 32'h0);                      // stop; last step 1->0
      rd(N0, 32'd0, "R9 value after stop edge");
      idle(3);
      rd(N0, 32'd0, "R9 held after stop");

      // R10 / R11 on stopped channel 0
      wr(N0, 32'h1234);
      rd(N0, 32'd0, "R10 count write ignored");
      wr(C0, 32'hFFFF_F60C);
      rd(C0, 32'h60C, "R10 R11 high bits zero, spare bits stored");
      idle(2);
      rd(N0, 32'd0, "R11 spare bits do not count");
      wr(C0, 32'h0);

      // up counter, reload, interrupt disabled, channel 1
      wr(L1, 32'hFFFF_FFFD);
      wr(C1, 32'h20);
      wr(C1, 32'h90);
      rd(N1, 32'hFFFF_FFFD, "R3 ch1 loaded");
      idle(1);
      rd(N1, 32'hFFFF_FFFE, "R4 up step");
      idle(1);
      rd(N1, 32'hFFFF_FFFF, "R4 up to all-ones");
      idle(1);
      rd(N1, 32'hFFFF_FFFD, "R5 up rollover reload");
      rd(C1, 32'h190, "R6 ch1 flag set");
      idle(1);
      ck_irq(1'b0, "R8 flag without enable");
      wr(C1, 32'h190);                    // count FE -> FF
      rd(C1, 32'h90, "R6 ch1 ack");
      rd(N1, 32'hFFFF_FFFF, "R4 ch1 at all-ones");
      wr(C1, 32'h20);                     // load beats wrap
      rd(N1, 32'hFFFF_FFFD, "R3 load wins over wrap");
      rd(C1, 32'h20, "R6 no event under load");

      // single shot down, channel 1
      wr(L1, 32'd2);
      wr(C1, 32'h20);
      wr(C1, 32'hC2);
      idle(2);
      rd(N1, 32'd0, "R4 ch1 down to zero");
      idle(1);
      rd(N1, 32'hFFFF_FFFF, "R5 wrap without reload");
      rd(C1, 32'h142, "R5 enable cleared, flag set");
      idle(1);
      ck_irq(1'b1, "R8 ch1 irq");
      rd(N1, 32'hFFFF_FFFF, "R5 stopped after event");
      wr(C1, 32'h142);
      rd(C1, 32'h42, "R6 ch1 single shot ack");
      idle(1);
      ck_irq(1'b0, "R8 ch1 irq cleared");

      // R12 load and enable in one write, channel 0
      wr(L0, 32'd10);
      wr(C0, 32'hA0);
      rd(N0, 32'd10, "R12 loaded by combined write");
      idle(2);
      rd(N0, 32'd10, "R12 held while load set");
      wr(C0, 32'h80);
      rd(N0, 32'd10, "R12 no step on clearing edge");
      idle(1);
      rd(N0, 32'd11, "R12 first step");
      idle(1);
      rd(N0, 32'd12, "R12 second step");

      #5;
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule